// File: doc/BRIEF.md
# I2C Slave Address Responder

This block is the slave half of a byte-oriented I2C controller. It samples the SCL and SDA lines with the system clock and finds START and STOP conditions. It shifts each byte in MSB first and compares the 7-bit address part with a programmable own address. When it answers, it pulls SDA low in the acknowledge slot. Every bus event it reports leaves an 8-bit status code and a pending interrupt for the host. SCL then stays held low until the host clears that interrupt.

A host-owned acknowledge-enable flag decides whether the block takes part in transfers. With the flag low, the block stays detached: it still tracks START, STOP and the serial bits, but it never answers its own address. A global enable input, when low, drops the block off the bus and discards everything it knew about the transfer in progress. In transmit mode, the host supplies each outgoing byte before clearing the interrupt.

Top module: `i2c_slave_responder`

## Requirements
- R1: After reset, and whenever the global enable is low, status is F8h, the interrupt flag is 0 and neither SCL nor SDA is pulled low.
- R2: With acknowledge-enable at 1, an address byte whose upper seven bits equal the own address and whose bit 0 is 0 (write) is acknowledged with SDA low, and status 60h is posted with the interrupt.
- R3: An address byte whose upper seven bits differ from the own address gets no acknowledge and no interrupt.
- R4: With acknowledge-enable at 0, the own address gets no acknowledge and no interrupt. After the flag is set to 1 again, the next START followed by the own address is recognised.
- R5: As an addressed receiver, a data byte is captured MSB first onto the received-byte output. With acknowledge-enable at 1 it is acknowledged and status 80h is posted. With the flag at 0 it gets no acknowledge, status 88h is posted, and later bytes are ignored.
- R6: An own-address byte with bit 0 at 1 (read) is acknowledged with status A8h. After the interrupt is cleared, the byte the host presents is shifted out MSB first.
- R7: After a transmitted byte, a master acknowledge gives status B8h if acknowledge-enable was 1 when that byte was loaded, and C8h if it was 0. A master not-acknowledge gives C0h.
- R8: Once the C8h interrupt is cleared, the block releases SDA and is no longer addressed, so any further byte the master reads is FFh.
- R9: The interrupt is raised only while SCL is low. SCL is held low for as long as the interrupt is pending and is released when it is cleared.
- R10: A host write of 0 to the interrupt bit clears it, and the status returns to F8h. A write of 1 has no effect. Status bits 2..0 are always 0, and the status is F8h exactly when no interrupt is pending.
- R11: Dropping the global enable releases both lines, clears the interrupt and loses the transfer. Bytes clocked after enable returns, with no new START, get no acknowledge and no interrupt.
- R12: A STOP returns the block to idle. A repeated START during an addressed transfer starts a new address phase that is recognised normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostEnable | input | 1 | Global enable; low detaches the block and clears its state |
| ackEnable | input | 1 | Acknowledge-enable flag owned by the host |
| ownAddr | input | BYTE_W-1 | Own 7-bit slave address |
| txByte | input | BYTE_W | Next byte to transmit, taken when the interrupt is cleared |
| hostWrEn | input | 1 | One-cycle strobe of a host write to the interrupt bit |
| hostWrIntBit | input | 1 | Value written to the interrupt bit (0 clears, 1 ignored) |
| sclIn | input | 1 | Level of the SCL line |
| sdaIn | input | 1 | Level of the SDA line |
| sclDriveLow | output | 1 | Pull SCL low (open-drain enable) |
| sdaDriveLow | output | 1 | Pull SDA low (open-drain enable) |
| intFlag | output | 1 | Interrupt pending |
| statusCode | output | 8 | Current status code |
| rxByte | output | BYTE_W | Last byte received as an addressed receiver |

## Verification
A wrong phase or a bit counter that is off by one shows at the ports within one byte time. The acknowledge then lands in the wrong slot, or SDA moves while SCL is high, and the master model reads a wrong acknowledge bit or a corrupted byte. A wrong decision on a byte boundary gives an unexpected status code or an interrupt the scoreboard does not expect, seen about three clocks after the acknowledge-slot SCL falls. Stale state after a disable, or after the C8h release, shows on the next byte as an acknowledge or an interrupt that should not be there, or as a read value other than FFh.

// File: rtl/i2c_resp_pkg.sv
package i2c_resp_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ADDR_ACK,
    PH_RX,
    PH_RX_ACK,
    PH_TX,
    PH_TX_ACK,
    PH_TX_END,
    PH_IGNORE
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic captureRx;
    logic loadTx;
    logic shiftTx;
  } dp_ctrl_t;

  // observations from datapath to control
  typedef struct packed {
    logic startEv;
    logic stopEv;
    logic sclRise;
    logic sclFall;
    logic sclLvl;
    logic sdaLvl;
    logic addrMatch;
    logic rwBit;
    logic byteDone;
    logic txBit;
  } dp_stat_t;

  localparam logic [7:0] STS_NONE      = 8'hF8;
  localparam logic [7:0] STS_ADDR_WR   = 8'h60;
  localparam logic [7:0] STS_RX_ACK    = 8'h80;
  localparam logic [7:0] STS_RX_NACK   = 8'h88;
  localparam logic [7:0] STS_ADDR_RD   = 8'hA8;
  localparam logic [7:0] STS_TX_ACK    = 8'hB8;
  localparam logic [7:0] STS_TX_NACK   = 8'hC0;
  localparam logic [7:0] STS_TX_LAST   = 8'hC8;

endpackage

// File: rtl/i2c_resp_datapath.sv
module i2c_resp_datapath
  import i2c_resp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-2:0] ownAddr,
  input  logic [BYTE_W-1:0] txByte,
  input  dp_ctrl_t          ctrl,
  output dp_stat_t          stat,
  output logic [BYTE_W-1:0] rxByte
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic                   sclPrev;
  logic                   sdaPrev;
  logic                   sclLvl;
  logic                   sdaLvl;
  logic [BYTE_W-1:0]      shiftIn;
  logic [BYTE_W-1:0]      txShift;
  logic [CNT_W-1:0]       bitCnt;

  // line synchronizer, depth chosen by parameter
  if (SYNC_STAGES == 1) begin : g_sync_one
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sclPipe <= '1;
        sdaPipe <= '1;
      end else begin
        sclPipe <= sclIn;
        sdaPipe <= sdaIn;
      end
    end
  end else begin : g_sync_many
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sclPipe <= '1;
        sdaPipe <= '1;
      end else begin
        sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
        sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      end
    end
  end

  assign sclLvl = sclPipe[SYNC_STAGES-1];
  assign sdaLvl = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclLvl;
      sdaPrev <= sdaLvl;
    end
  end

  // serial bits are shifted in on every rising SCL, addressed or not
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftIn <= '0;
    end else if (sclLvl && !sclPrev) begin
      shiftIn <= {shiftIn[BYTE_W-2:0], sdaLvl};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      txShift <= '1;
      rxByte  <= '0;
    end else if (!enable) begin
      bitCnt  <= '0;
      txShift <= '1;
    end else begin
      if (ctrl.cntClr) begin
        bitCnt <= '0;
      end else if (ctrl.cntInc) begin
        bitCnt <= bitCnt + 1'b1;
      end
      if (ctrl.loadTx) begin
        txShift <= txByte;
      end else if (ctrl.shiftTx) begin
        txShift <= {txShift[BYTE_W-2:0], 1'b1};
      end
      if (ctrl.captureRx) begin
        rxByte <= shiftIn;
      end
    end
  end

  always_comb begin
    stat.startEv   = sclLvl && sclPrev && sdaPrev && !sdaLvl;
    stat.stopEv    = sclLvl && sclPrev && !sdaPrev && sdaLvl;
    stat.sclRise   = sclLvl && !sclPrev;
    stat.sclFall   = !sclLvl && sclPrev;
    stat.sclLvl    = sclLvl;
    stat.sdaLvl    = sdaLvl;
    stat.addrMatch = (shiftIn[BYTE_W-1:1] == ownAddr);
    stat.rwBit     = shiftIn[0];
    stat.byteDone  = (bitCnt == CNT_W'(BYTE_W));
    stat.txBit     = txShift[BYTE_W-1];
  end

endmodule

// File: rtl/i2c_resp_control.sv
module i2c_resp_control
  import i2c_resp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       ackEnable,
  input  logic       hostWrEn,
  input  logic       hostWrIntBit,
  input  dp_stat_t   stat,
  output dp_ctrl_t   ctrl,
  output logic       intFlag,
  output logic [7:0] statusCode,
  output logic       sclDriveLow,
  output logic       sdaDriveLow
);

  phase_t phase;
  logic   ackDrive;
  logic   isRead;
  logic   nackPend;
  logic   lastByte;
  logic   ackSeen;
  logic   clearReq;

  assign clearReq = hostWrEn && !hostWrIntBit && intFlag;

  always_comb begin
    ctrl = '0;
    if (stat.startEv) begin
      ctrl.cntClr = 1'b1;
    end else begin
      unique case (phase)
        PH_ADDR: begin
          ctrl.cntInc = stat.sclRise;
        end
        PH_RX: begin
          ctrl.cntInc    = stat.sclRise;
          ctrl.captureRx = stat.sclFall && stat.byteDone;
        end
        PH_TX: begin
          ctrl.cntInc  = stat.sclRise;
          ctrl.shiftTx = stat.sclFall;
          ctrl.loadTx  = clearReq;
        end
        PH_ADDR_ACK, PH_RX_ACK, PH_TX_ACK: begin
          ctrl.cntClr = stat.sclFall;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      ackDrive   <= 1'b0;
      isRead     <= 1'b0;
      nackPend   <= 1'b0;
      lastByte   <= 1'b0;
      ackSeen    <= 1'b0;
      intFlag    <= 1'b0;
      statusCode <= STS_NONE;
    end else if (!enable) begin
      phase      <= PH_IDLE;
      ackDrive   <= 1'b0;
      isRead     <= 1'b0;
      nackPend   <= 1'b0;
      lastByte   <= 1'b0;
      ackSeen    <= 1'b0;
      intFlag    <= 1'b0;
      statusCode <= STS_NONE;
    end else begin
      if (clearReq) begin
        intFlag    <= 1'b0;
        statusCode <= STS_NONE;
        if (phase == PH_TX_END) phase <= PH_IGNORE;
      end
      if (stat.startEv) begin
        phase    <= PH_ADDR;
        ackDrive <= 1'b0;
      end else if (stat.stopEv) begin
        phase    <= PH_IDLE;
        ackDrive <= 1'b0;
      end else begin
        unique case (phase)
          PH_ADDR: begin
            if (stat.sclFall && stat.byteDone) begin
              if (stat.addrMatch && ackEnable) begin
                ackDrive <= 1'b1;
                isRead   <= stat.rwBit;
                phase    <= PH_ADDR_ACK;
              end else begin
                phase <= PH_IGNORE;
              end
            end
          end
          PH_ADDR_ACK: begin
            if (stat.sclFall) begin
              ackDrive   <= 1'b0;
              intFlag    <= 1'b1;
              statusCode <= isRead ? STS_ADDR_RD : STS_ADDR_WR;
              phase      <= isRead ? PH_TX : PH_RX;
            end
          end
          PH_RX: begin
            if (stat.sclFall && stat.byteDone) begin
              ackDrive <= ackEnable;
              nackPend <= !ackEnable;
              phase    <= PH_RX_ACK;
            end
          end
          PH_RX_ACK: begin
            if (stat.sclFall) begin
              ackDrive   <= 1'b0;
              intFlag    <= 1'b1;
              statusCode <= nackPend ? STS_RX_NACK : STS_RX_ACK;
              phase      <= nackPend ? PH_IGNORE : PH_RX;
            end
          end
          PH_TX: begin
            if (clearReq) lastByte <= !ackEnable;
            if (stat.sclFall && stat.byteDone) phase <= PH_TX_ACK;
          end
          PH_TX_ACK: begin
            if (stat.sclRise) ackSeen <= !stat.sdaLvl;
            if (stat.sclFall) begin
              intFlag <= 1'b1;
              if (!ackSeen) begin
                statusCode <= STS_TX_NACK;
                phase      <= PH_TX_END;
              end else if (lastByte) begin
                statusCode <= STS_TX_LAST;
                phase      <= PH_TX_END;
              end else begin
                statusCode <= STS_TX_ACK;
                phase      <= PH_TX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sclDriveLow = intFlag;
  assign sdaDriveLow = ackDrive || ((phase == PH_TX) && !intFlag && !stat.txBit);

endmodule

// File: rtl/i2c_slave_responder.sv
module i2c_slave_responder
  import i2c_resp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostEnable,
  input  logic              ackEnable,
  input  logic [BYTE_W-2:0] ownAddr,
  input  logic [BYTE_W-1:0] txByte,
  input  logic              hostWrEn,
  input  logic              hostWrIntBit,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  output logic              intFlag,
  output logic [7:0]        statusCode,
  output logic [BYTE_W-1:0] rxByte
);

  dp_ctrl_t dpCtrl;
  dp_stat_t dpStat;
  logic     sclLvlW;

  i2c_resp_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .BYTE_W     (BYTE_W)
  ) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .enable (hostEnable),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .ownAddr(ownAddr),
    .txByte (txByte),
    .ctrl   (dpCtrl),
    .stat   (dpStat),
    .rxByte (rxByte)
  );

  i2c_resp_control i_control (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (hostEnable),
    .ackEnable   (ackEnable),
    .hostWrEn    (hostWrEn),
    .hostWrIntBit(hostWrIntBit),
    .stat        (dpStat),
    .ctrl        (dpCtrl),
    .intFlag     (intFlag),
    .statusCode  (statusCode),
    .sclDriveLow (sclDriveLow),
    .sdaDriveLow (sdaDriveLow)
  );

  assign sclLvlW = dpStat.sclLvl;

endmodule

// File: rtl/i2c_resp_checker.sv
module i2c_resp_checker (
  input logic       clk,
  input logic       rstN,
  input logic       hostEnable,
  input logic       hostWrEn,
  input logic       hostWrIntBit,
  input logic       intFlag,
  input logic [7:0] statusCode,
  input logic       sclDriveLow,
  input logic       sdaDriveLow,
  input logic       sclLvl
);

  assert_status_low_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    statusCode[2:0] == 3'b000);

  assert_flag_tracks_status_R10: assert property (@(posedge clk) disable iff (!rstN)
    intFlag == (statusCode != 8'hF8));

  assert_write_one_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (intFlag && hostWrEn && hostWrIntBit) |=> (intFlag || !hostEnable));

  assert_disable_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !hostEnable |=> (!intFlag && !sdaDriveLow && !sclDriveLow && statusCode == 8'hF8));

  assert_raise_on_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intFlag) |-> !sclLvl);

  assert_stretch_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sclDriveLow && !(hostWrEn && !hostWrIntBit)) |=> (sclDriveLow || !hostEnable));

endmodule

bind i2c_slave_responder i2c_resp_checker i_checker (
  .clk         (clk),
  .rstN        (rstN),
  .hostEnable  (hostEnable),
  .hostWrEn    (hostWrEn),
  .hostWrIntBit(hostWrIntBit),
  .intFlag     (intFlag),
  .statusCode  (statusCode),
  .sclDriveLow (sclDriveLow),
  .sdaDriveLow (sdaDriveLow),
  .sclLvl      (sclLvlW)
);

// File: tb/test_i2c_slave_responder.sv
`timescale 1ns/1ps
module test_i2c_slave_responder;

  localparam int HALF = 10;
  localparam logic [6:0] OWN = 7'h5A;
  localparam logic [7:0] OWN_W = {OWN, 1'b0};
  localparam logic [7:0] OWN_R = {OWN, 1'b1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostEnable, ackEnable, hostWrEn, hostWrIntBit;
  logic [6:0] ownAddr;
  logic [7:0] txByte;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sclLine, sdaLine;
  logic sclDriveLow, sdaDriveLow, intFlag;
  logic [7:0] statusCode, rxByte;

  int runCnt = 0;
  int failCnt = 0;

  typedef struct {
    logic [7:0] status;
    logic [7:0] nextTx;
    bit         dropEn;
    string      tag;
  } exp_t;
  exp_t expQ[$];

  always #10 clk = ~clk;

  assign sclLine = sclM & ~sclDriveLow;
  assign sdaLine = sdaM & ~sdaDriveLow;

  i2c_slave_responder i_i2c_slave_responder (
    .clk(clk), .rstN(rstN), .hostEnable(hostEnable), .ackEnable(ackEnable),
    .ownAddr(ownAddr), .txByte(txByte), .hostWrEn(hostWrEn), .hostWrIntBit(hostWrIntBit),
    .sclIn(sclLine), .sdaIn(sdaLine), .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .intFlag(intFlag), .statusCode(statusCode), .rxByte(rxByte)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    runCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pushExp(input logic [7:0] st, input logic [7:0] tx, input bit drop, input string tag);
    exp_t e;
    e.status = st; e.nextTx = tx; e.dropEn = drop; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xferBit(input bit dOut, output bit dIn);
    sdaM = dOut;
    cyc(HALF);
    sclM = 1'b1;
    while (!sclLine) @(negedge clk);
    cyc(HALF / 2);
    dIn = sdaLine;
    cyc(HALF / 2);
    sclM = 1'b0;
    cyc(3);
  endtask

  task automatic mStart();
    sdaM = 1'b1;
    cyc(HALF);
    sclM = 1'b1;
    while (!sclLine) @(negedge clk);
    cyc(HALF);
    sdaM = 1'b0;
    cyc(HALF);
    sclM = 1'b0;
    cyc(3);
  endtask

  task automatic mStop();
    sdaM = 1'b0;
    cyc(HALF);
    sclM = 1'b1;
    while (!sclLine) @(negedge clk);
    cyc(HALF);
    sdaM = 1'b1;
    cyc(HALF);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    bit d;
    for (int i = 7; i >= 0; i--) xferBit(b[i], d);
    xferBit(1'b1, ack);
  endtask

  task automatic readByte(input bit ackOut, output logic [7:0] b);
    bit d;
    for (int i = 7; i >= 0; i--) begin
      xferBit(1'b1, d);
      b[i] = d;
    end
    xferBit(ackOut, d);
  endtask

  // scoreboard monitor: acts as host on every interrupt
  initial begin
    exp_t e;
    hostEnable = 1'b1; hostWrEn = 1'b0; hostWrIntBit = 1'b0; txByte = 8'h00;
    @(posedge rstN);
    forever begin
      @(posedge intFlag);
      @(negedge clk);
      if (expQ.size() == 0) begin
        check(1'b0, "R3", "unexpected interrupt status", statusCode, 8'hF8);
      end else begin
        e = expQ.pop_front();
        check(statusCode == e.status, e.tag, "status code", statusCode, e.status);
        cyc(4);
        check(sclDriveLow && !sclLine, "R9", "SCL held low while pending", sclDriveLow, 1);
        if (e.dropEn) begin
          hostEnable = 1'b0;
          cyc(2);
          check(!intFlag && statusCode == 8'hF8 && !sclDriveLow && !sdaDriveLow,
                "R11", "quiet after disable", {intFlag, statusCode}, 8'hF8);
          hostEnable = 1'b1;
        end else begin
          txByte = e.nextTx;
          hostWrEn = 1'b1; hostWrIntBit = 1'b1;
          @(negedge clk);
          hostWrEn = 1'b0;
          cyc(2);
          check(intFlag == 1'b1, "R10", "write of 1 leaves flag set", intFlag, 1);
          cyc(14);
          hostWrEn = 1'b1; hostWrIntBit = 1'b0;
          @(negedge clk);
          hostWrEn = 1'b0;
          @(negedge clk);
          check(!intFlag && statusCode == 8'hF8, "R10", "clear returns status F8", statusCode, 8'hF8);
          check(!sclDriveLow, "R9", "SCL released after clear", sclDriveLow, 0);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] b;
    ackEnable = 1'b1;
    ownAddr = OWN;
    cyc(5);
    check(statusCode == 8'hF8 && !intFlag, "R1", "status in reset", statusCode, 8'hF8);
    rstN = 1'b1;
    cyc(5);
    check(!sclDriveLow && !sdaDriveLow && !intFlag && statusCode == 8'hF8,
          "R1", "idle after reset", {sclDriveLow, sdaDriveLow, intFlag}, 0);

    // addressed write, two data bytes
    pushExp(8'h60, 8'h00, 1'b0, "R2");
    mStart();
    sendByte(OWN_W, a);
    check(a == 1'b0, "R2", "own write address acknowledged", a, 0);
    pushExp(8'h80, 8'h00, 1'b0, "R5");
    sendByte(8'hC3, a);
    check(a == 1'b0, "R5", "data C3 acknowledged", a, 0);
    cyc(5);
    check(rxByte == 8'hC3, "R5", "received byte", rxByte, 8'hC3);
    pushExp(8'h80, 8'h00, 1'b0, "R5");
    sendByte(8'h3C, a);
    cyc(5);
    check(rxByte == 8'h3C, "R5", "received second byte", rxByte, 8'h3C);
    mStop();
    cyc(10);
    check(statusCode == 8'hF8 && !intFlag, "R12", "idle after STOP", statusCode, 8'hF8);

    // wrong address
    mStart();
    sendByte({7'h11, 1'b0}, a);
    check(a == 1'b1, "R3", "foreign address not acknowledged", a, 1);
    cyc(40);
    check(!intFlag, "R3", "no interrupt for foreign address", intFlag, 0);
    mStop();

    // detached: own address ignored, then resume
    ackEnable = 1'b0;
    mStart();
    sendByte(OWN_W, a);
    check(a == 1'b1, "R4", "own address ignored while detached", a, 1);
    cyc(40);
    check(!intFlag, "R4", "no interrupt while detached", intFlag, 0);
    mStop();
    ackEnable = 1'b1;
    pushExp(8'h60, 8'h00, 1'b0, "R4");
    mStart();
    sendByte(OWN_W, a);
    check(a == 1'b0, "R4", "address recognised after resume", a, 0);
    ackEnable = 1'b0;
    pushExp(8'h88, 8'h00, 1'b0, "R5");
    sendByte(8'h77, a);
    check(a == 1'b1, "R5", "data not acknowledged with flag 0", a, 1);
    cyc(5);
    check(rxByte == 8'h77, "R5", "byte captured before release", rxByte, 8'h77);
    sendByte(8'h55, a);
    check(a == 1'b1, "R5", "later byte ignored", a, 1);
    check(!intFlag, "R5", "no interrupt after 88", intFlag, 0);
    mStop();
    ackEnable = 1'b1;

    // addressed transmit: B8 then C8, then released
    pushExp(8'hA8, 8'hA5, 1'b0, "R6");
    mStart();
    sendByte(OWN_R, a);
    check(a == 1'b0, "R6", "own read address acknowledged", a, 0);
    pushExp(8'hB8, 8'h0F, 1'b0, "R7");
    readByte(1'b0, b);
    check(b == 8'hA5, "R6", "first transmitted byte", b, 8'hA5);
    wait (intFlag);
    @(negedge clk);
    ackEnable = 1'b0;
    pushExp(8'hC8, 8'h00, 1'b0, "R7");
    readByte(1'b0, b);
    check(b == 8'h0F, "R7", "last transmitted byte", b, 8'h0F);
    wait (!intFlag);
    cyc(2);
    readByte(1'b1, b);
    check(b == 8'hFF, "R8", "SDA released after C8", b, 8'hFF);
    check(!intFlag && !sdaDriveLow, "R8", "no interrupt after C8 release", intFlag, 0);
    mStop();
    ackEnable = 1'b1;

    // master NACK
    pushExp(8'hA8, 8'h81, 1'b0, "R6");
    mStart();
    sendByte(OWN_R, a);
    pushExp(8'hC0, 8'h00, 1'b0, "R7");
    readByte(1'b1, b);
    check(b == 8'h81, "R6", "byte before NACK", b, 8'h81);
    mStop();

    // repeated START
    pushExp(8'h60, 8'h00, 1'b0, "R12");
    mStart();
    sendByte(OWN_W, a);
    pushExp(8'h80, 8'h00, 1'b0, "R12");
    sendByte(8'h12, a);
    pushExp(8'hA8, 8'h42, 1'b0, "R12");
    mStart();
    sendByte(OWN_R, a);
    check(a == 1'b0, "R12", "address after repeated START", a, 0);
    pushExp(8'hC0, 8'h00, 1'b0, "R7");
    readByte(1'b1, b);
    check(b == 8'h42, "R12", "byte after repeated START", b, 8'h42);
    mStop();

    // global disable mid transfer
    pushExp(8'h60, 8'h00, 1'b0, "R2");
    mStart();
    sendByte(OWN_W, a);
    pushExp(8'h80, 8'h00, 1'b1, "R11");
    sendByte(8'h99, a);
    wait (!intFlag);
    cyc(4);
    sendByte(OWN_W, a);
    check(a == 1'b1, "R11", "no answer after state loss", a, 1);
    cyc(20);
    check(!intFlag, "R11", "no interrupt after state loss", intFlag, 0);
    mStop();

    cyc(20);
    check(expQ.size() == 0, "R2", "all expected interrupts seen", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

endmodule